// File: doc/BRIEF.md
# General-Purpose I/O Port Controller

This block controls one port of up to 32 general-purpose pins from a plain synchronous register bus that carries an address, a write strobe, write data and registered read data. Software sets the pin levels through an output level register and picks which pins drive through a direction register. It reads the synchronized pin levels back from a read-only sampled-input register. A write-only bit-set alias raises chosen output bits in a single bus write, so no read-modify-write sequence is needed and no other bit of the output register can be disturbed.

A mask parameter lists the pins the port actually has. Every bit outside the mask is held at zero in storage, in read data and on the pin outputs and enables. The bus carries one access per cycle. Read data appears one cycle after the address. Reset is active-low and synchronous.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, the output level register, the direction register and the sampled-input register clear to zero, so after that edge `pin_out`, `pin_oe` and `bus_rdata` are all zero and every pin is an input.
- R2: A write at byte offset 0x00 loads the output level register with `bus_wdata` masked by `PIN_MASK`. A read at 0x00 returns that masked value.
- R3: A write at byte offset 0x04 sets to 1 every output level bit whose `bus_wdata` bit is 1 and lies inside `PIN_MASK`. Bits written as 0 keep their previous value.
- R4: A read at offset 0x04 always returns zero.
- R5: `pin_out` follows the output level register. `pin_oe` bit n is 1 only when direction bit n is 1 and `PIN_MASK` bit n is 1.
- R6: Pin levels pass through two synchronizer flops and one capture flop. With the address held at 0x10, a change on `pin_in` shows in `bus_rdata` at the fourth rising edge after the change and not before. Bits outside `PIN_MASK` read as 0.
- R7: Byte offset 0x14 holds the direction register (1 means output). It can be read and written, and bits outside `PIN_MASK` read as 0.
- R8: A read at any offset other than 0x00, 0x04, 0x10 and 0x14 returns zero. A write to any offset other than 0x00, 0x04 and 0x14 changes no register.
- R9: `bus_rdata` is registered: after each rising edge it shows the register selected by the address present at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | PIN_W (32) | Write data |
| bus_rdata | output | PIN_W (32) | Read data, registered |
| pin_in | input | PIN_W (32) | Asynchronous pin levels |
| pin_out | output | PIN_W (32) | Level to drive on each pin |
| pin_oe | output | PIN_W (32) | Drive enable for each pin |

## Verification
On every cycle, the assertions check that each output write, bit-set write and direction write lands one cycle later with the right masked value. They also check that nothing else moves the output level register, that the alias offset and unmapped offsets read zero, that unimplemented bits never show in read data, and that reset clears all outputs. Only the bench's scenarios show the full register contents across chains of writes, the exact four-edge latency from a pin change to read data, and recovery from a reset applied in the middle of a run.

// File: rtl/gpio_port_pkg.sv
// Package: shared register offsets and register-select type for the
// general-purpose I/O port controller.
// Assumes byte offsets on a bus that makes one access per cycle.
package gpio_port_pkg;

    localparam int unsigned OFS_LEVEL = 'h00;
    localparam int unsigned OFS_SET   = 'h04;
    localparam int unsigned OFS_INPUT = 'h10;
    localparam int unsigned OFS_DIR   = 'h14;

    typedef enum logic [2:0] {
        SEL_LEVEL,
        SEL_SET,
        SEL_INPUT,
        SEL_DIR,
        SEL_NONE
    } reg_sel_e;

endpackage

// File: rtl/gpio_port_outregs.sv
// Output level and direction registers.
// Writes to the level register load it. Writes to the set alias OR
// into it, and the alias wins for its 1 bits if both strobes are ever high.
// Only bits inside PIN_MASK have flops. The other bits are tied to zero.
module gpio_port_outregs #(
    parameter int unsigned PIN_W    = 32,
    parameter logic [PIN_W-1:0] PIN_MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_level,
    input  logic             wr_set,
    input  logic             wr_dir,
    input  logic [PIN_W-1:0] wdata,
    output logic [PIN_W-1:0] level_q,
    output logic [PIN_W-1:0] dir_q
);

    for (genvar b = 0; b < PIN_W; b++) begin : g_bit
        if (PIN_MASK[b]) begin : g_impl
            // Per-pin output level: load, then set alias on top.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    level_q[b] <= 1'b0;
                end else if (wr_set && wdata[b]) begin
                    level_q[b] <= 1'b1;
                end else if (wr_level) begin
                    level_q[b] <= wdata[b];
                end
            end

            // Per-pin direction bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    dir_q[b] <= 1'b0;
                end else if (wr_dir) begin
                    dir_q[b] <= wdata[b];
                end
            end
        end else begin : g_absent
            assign level_q[b] = 1'b0;
            assign dir_q[b]   = 1'b0;
        end
    end

endmodule

// File: rtl/gpio_port_insync.sv
// Input sampling path: SYNC_STAGES synchronizer flops per pin, then a
// capture flop that forms the sampled-input register.
// Assumes pin_in is asynchronous. Bits outside PIN_MASK are forced to zero.
module gpio_port_insync #(
    parameter int unsigned PIN_W       = 32,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [PIN_W-1:0] PIN_MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] pin_in,
    output logic [PIN_W-1:0] in_q
);

    logic [PIN_W-1:0] stage_q [SYNC_STAGES];

    // Synchronizer chain: stage 0 takes the pins, later stages shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < int'(SYNC_STAGES); s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= pin_in;
            for (int s = 1; s < int'(SYNC_STAGES); s++) stage_q[s] <= stage_q[s-1];
        end
    end

    // Capture register: masked copy of the last synchronizer stage.
    always_ff @(posedge clk) begin
        if (!rst_n) in_q <= '0;
        else        in_q <= stage_q[SYNC_STAGES-1] & PIN_MASK;
    end

endmodule

// File: rtl/gpio_port_rdport.sv
// Registered read multiplexer. Returns the register picked by sel one
// cycle later. The set alias and unmapped offsets return zero.
module gpio_port_rdport
    import gpio_port_pkg::*;
#(
    parameter int unsigned PIN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  reg_sel_e         sel,
    input  logic [PIN_W-1:0] level_q,
    input  logic [PIN_W-1:0] dir_q,
    input  logic [PIN_W-1:0] in_q,
    output logic [PIN_W-1:0] rdata
);

    logic [PIN_W-1:0] rd_next;

    // Select the read source for the current address.
    always_comb begin
        unique case (sel)
            SEL_LEVEL: rd_next = level_q;
            SEL_INPUT: rd_next = in_q;
            SEL_DIR:   rd_next = dir_q;
            default:   rd_next = '0;
        endcase
    end

    // Register the read data.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_next;
    end

endmodule

// File: rtl/gpio_port_ctrl.sv
// Top level of the general-purpose I/O port controller.
// Decodes the byte offset and drives the output, input and read submodules.
// Assumes at most one bus access per cycle and a synchronous active-low reset.
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned PIN_W       = 32,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [PIN_W-1:0] PIN_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [PIN_W-1:0]  bus_wdata,
    output logic [PIN_W-1:0]  bus_rdata,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe
);

    reg_sel_e         sel;
    logic [PIN_W-1:0] level_q;
    logic [PIN_W-1:0] dir_q;
    logic [PIN_W-1:0] in_q;

    // Address decode to a register select.
    always_comb begin
        if      (bus_addr == ADDR_W'(OFS_LEVEL)) sel = SEL_LEVEL;
        else if (bus_addr == ADDR_W'(OFS_SET))   sel = SEL_SET;
        else if (bus_addr == ADDR_W'(OFS_INPUT)) sel = SEL_INPUT;
        else if (bus_addr == ADDR_W'(OFS_DIR))   sel = SEL_DIR;
        else                                     sel = SEL_NONE;
    end

    gpio_port_outregs #(
        .PIN_W    (PIN_W),
        .PIN_MASK (PIN_MASK)
    ) u_outregs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_level (bus_we && (sel == SEL_LEVEL)),
        .wr_set   (bus_we && (sel == SEL_SET)),
        .wr_dir   (bus_we && (sel == SEL_DIR)),
        .wdata    (bus_wdata),
        .level_q  (level_q),
        .dir_q    (dir_q)
    );

    gpio_port_insync #(
        .PIN_W       (PIN_W),
        .SYNC_STAGES (SYNC_STAGES),
        .PIN_MASK    (PIN_MASK)
    ) u_insync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .in_q   (in_q)
    );

    gpio_port_rdport #(
        .PIN_W (PIN_W)
    ) u_rdport (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .level_q (level_q),
        .dir_q   (dir_q),
        .in_q    (in_q),
        .rdata   (bus_rdata)
    );

    assign pin_out = level_q;
    assign pin_oe  = dir_q & PIN_MASK;

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
// Checker for gpio_port_ctrl, attached by bind. Watches only top-level ports.
module gpio_port_ctrl_chk #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned PIN_W  = 32,
    parameter logic [PIN_W-1:0] PIN_MASK = '1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [PIN_W-1:0]  bus_wdata,
    input logic [PIN_W-1:0]  bus_rdata,
    input logic [PIN_W-1:0]  pin_out,
    input logic [PIN_W-1:0]  pin_oe
);

    logic mapped_rd;
    logic moves_level;
    assign mapped_rd   = (bus_addr == ADDR_W'('h00)) || (bus_addr == ADDR_W'('h04)) ||
                         (bus_addr == ADDR_W'('h10)) || (bus_addr == ADDR_W'('h14));
    assign moves_level = bus_we && ((bus_addr == ADDR_W'('h00)) || (bus_addr == ADDR_W'('h04)));

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (pin_out == '0 && pin_oe == '0 && bus_rdata == '0));

    assert_level_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'('h00)) |=> pin_out == ($past(bus_wdata) & PIN_MASK));

    assert_set_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'('h04)) |=>
            pin_out == ($past(pin_out) | ($past(bus_wdata) & PIN_MASK)));

    assert_set_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'('h04)) |=> bus_rdata == '0);

    assert_dir_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'('h14)) |=> pin_oe == ($past(bus_wdata) & PIN_MASK));

    assert_unimpl_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~PIN_MASK) == '0);

    assert_unmapped_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped_rd |=> bus_rdata == '0);

    assert_level_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !moves_level |=> $stable(pin_out));

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .PIN_W    (PIN_W),
    .PIN_MASK (PIN_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/gpio_port_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_port_ctrl_bench;

    localparam logic [31:0] MASK = 32'hF0FF_FF7F;
    localparam int NVEC = 18;

    // {check, we, addr, wdata, expected rdata}
    typedef struct packed {
        logic        chk;
        logic        we;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 8'h00, 32'h0,          32'h0},           // R1 level reads 0
        '{1'b0, 1'b1, 8'h00, 32'hA5A5_5A5A, 32'h0},
        '{1'b1, 1'b0, 8'h00, 32'h0,          32'hA0A5_5A5A},   // R2 masked load
        '{1'b0, 1'b1, 8'h04, 32'h0F00_0081, 32'h0},
        '{1'b1, 1'b0, 8'h04, 32'h0,          32'h0},           // R4 alias reads 0
        '{1'b1, 1'b0, 8'h00, 32'h0,          32'hA0A5_5A5B},   // R3 set bit 0 only
        '{1'b0, 1'b1, 8'h04, 32'h0,          32'h0},
        '{1'b1, 1'b0, 8'h00, 32'h0,          32'hA0A5_5A5B},   // R3 zeros keep bits
        '{1'b0, 1'b1, 8'h14, 32'hFFFF_FFFF, 32'h0},
        '{1'b1, 1'b0, 8'h14, 32'h0,          32'hF0FF_FF7F},   // R7 masked direction
        '{1'b0, 1'b1, 8'h08, 32'h1234_5678, 32'h0},
        '{1'b1, 1'b0, 8'h08, 32'h0,          32'h0},           // R8 unmapped read
        '{1'b1, 1'b0, 8'h00, 32'h0,          32'hA0A5_5A5B},   // R8 write ignored
        '{1'b0, 1'b1, 8'h00, 32'h0,          32'h0},
        '{1'b0, 1'b1, 8'h04, 32'hFFFF_FFFF, 32'h0},
        '{1'b1, 1'b0, 8'h00, 32'h0,          32'hF0FF_FF7F},   // R3 set all
        '{1'b1, 1'b0, 8'hFC, 32'h0,          32'h0},           // R8 high offset
        '{1'b1, 1'b0, 8'h10, 32'h0,          32'h0}            // R6 idle pins
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    int n_chk = 0;
    int n_bad = 0;
    int n_cyc = 0;

    always #2 clk = ~clk;

    gpio_port_ctrl #(
        .ADDR_W (8), .PIN_W (32), .SYNC_STAGES (2), .PIN_MASK (MASK)
    ) u_gpio_port_ctrl (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_we (bus_we),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .pin_in (pin_in),
        .pin_out (pin_out), .pin_oe (pin_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at the falling edge, return just after the rising edge.
    task automatic cyc(input logic we, input logic [7:0] addr, input logic [31:0] wd);
        @(negedge clk);
        bus_we = we; bus_addr = addr; bus_wdata = wd;
        @(posedge clk); #1;
    endtask

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<20000 cycles", n_cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc(1'b0, 8'h00, 32'h0);
        check("R1 rdata", bus_rdata, 32'h0);
        check("R1 pin_out", pin_out, 32'h0);
        check("R1 pin_oe", pin_oe, 32'h0);
        rst_n = 1'b1;

        // R9 registered read: each entry returns data after its own edge.
        for (int i = 0; i < NVEC; i++) begin
            cyc(VECS[i].we, VECS[i].addr, VECS[i].wdata);
            if (VECS[i].chk) check($sformatf("R9 vector %0d", i), bus_rdata, VECS[i].exp);
        end

        check("R5 pin_out", pin_out, MASK);
        check("R5 pin_oe", pin_oe, MASK);

        // R6 input latency and masking.
        cyc(1'b0, 8'h10, 32'h0);
        @(negedge clk); pin_in = 32'h5555_AAAA;
        @(posedge clk); #1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        check("R6 not before fourth edge", bus_rdata, 32'h0);
        @(posedge clk); #1;
        check("R6 fourth edge", bus_rdata, 32'h5055_AA2A);

        // R5 direction cleared drops enables.
        cyc(1'b1, 8'h14, 32'h0000_0F00);
        check("R5 partial oe", pin_oe, 32'h0000_0F00);
        cyc(1'b1, 8'h14, 32'h0);
        check("R5 oe off", pin_oe, 32'h0);

        // R1 reset in mid-run.
        cyc(1'b1, 8'h14, 32'hFFFF_FFFF);
        @(negedge clk); rst_n = 1'b0; bus_we = 1'b0; bus_addr = 8'h10;
        @(posedge clk); #1;
        check("R1 mid reset out", pin_out, 32'h0);
        check("R1 mid reset oe", pin_oe, 32'h0);
        check("R1 mid reset rdata", bus_rdata, 32'h0);
        @(negedge clk); rst_n = 1'b1; pin_in = 32'h0;
        cyc(1'b0, 8'h14, 32'h0);
        cyc(1'b0, 8'h14, 32'h0);
        check("R1 dir after reset", bus_rdata, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule